// File: doc/BRIEF.md
# Vector Element Masked Write Sequencer

This block walks the element positions of one operation on a vector register group and decides, one element per clock, what happens to each destination element. Body elements, from the resume index up to the vector length, receive the result of a small element operation on two source operands. Elements that the packed mask register switches off either receive all-ones bytes or are skipped, depending on a mask-fill flag. Elements past the vector length are filled with all ones when a tail-fill flag is set. When the group multiplier is fractional, this tail reaches to the end of the physical register.

A start strobe latches the whole configuration. The block then drives a byte-enabled write port into a destination register-file model. It reads a 64-bit mask word and the two source operands through combinational read ports that are indexed by the current element. When the run ends, the block gives a one-cycle done pulse and clears the resume index it reports.

Top module: `vec_mask_wr_seq`

## Requirements
- R1: If the resume index at start is greater than or equal to the vector length, the block writes nothing, gives done on the first cycle after start, and reports a resume index of 0.
- R2: Body elements are visited in ascending order from the resume index to vector length minus one, one element per clock. Each write goes to byte address index × esz, where esz = 1 << elem_lg bytes. The byte enable has exactly the low esz bits set.
- R3: When no_mask is 0, element i is active only if bit (i mod 64) of mask word (i / 64) is 1. When no_mask is 1, every body element is active.
- R4: An inactive element is written with all-ones bytes when mask_fill is 1. When mask_fill is 0, the element is not written and uses no extra cycle beyond its own.
- R5: When tail_fill is 1, the elements from the vector length up to the total element count minus one are written with all ones, one per clock, after the body. When tail_fill is 0, no tail write or tail cycle occurs.
- R6: The total element count is (reg_bytes << emul) >> elem_lg. Here emul = elem_lg − sew_lg + m, clamped to 0 when negative. The signed group code m maps 000→0, 001→1, 010→2, 011→3, 101→−3, 110→−2, 111→−1.
- R7: Group code 100 is reserved. It sets illegal, which is held until the next accepted start. The block writes nothing and gives done on the first cycle after start.
- R8: busy is high from the cycle after an accepted start through the done cycle. done lasts exactly one cycle. vstart_out reads 0 outside the body phase, including at done. Nothing is written while idle.
- R9: The op_sel encoding for an active element is: 00 gives ~a, 01 gives a + b, 10 gives a ^ b, and 11 gives a − b. The result is truncated to esz bytes by the byte enable.
- R10: A start strobe while busy is ignored. The running operation continues with its latched configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and begin when idle |
| vstart_in | input | IDX_W | Resume index |
| vl_in | input | IDX_W | Vector length |
| no_mask | input | 1 | 1: all body elements active |
| mask_fill | input | 1 | Fill inactive elements with ones |
| tail_fill | input | 1 | Fill tail elements with ones |
| grp_code | input | 3 | Signed group multiplier code |
| elem_lg | input | ESZ_W | log2 of element size in bytes |
| sew_lg | input | 3 | log2 of selected element width in bytes |
| reg_bytes | input | VLENB_W | Register length in bytes |
| op_sel | input | 2 | Element operation select |
| mask_word_idx | output | MW_W | Mask word being read |
| mask_word | input | 64 | Mask word contents |
| src_idx | output | IDX_W | Element index of source read |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_be | output | ELEM_BYTES | Byte enables, relative to wr_addr |
| wr_data | output | DATA_W | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Reserved group code seen at last start |
| vstart_out | output | IDX_W | Current resume index, 0 when not in body |

## Verification
The assertions hold on every cycle for the following behaviours: the shape of the done pulse, silence while idle or after an illegal code, contiguous low byte enables, strictly rising addresses within a run, all-ones data in the tail, and a cleared resume index at done. The bench scenarios alone show which elements are written, because that needs the mask pattern, the clamped total count and the flag settings. Only the bench checks the exact operation results, the skipped masked-off elements when mask fill is off, and the exact cycle count of each run. It compares every write against a queue it builds from the requirements.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NOT = 2'b00,
        OP_ADD = 2'b01,
        OP_XOR = 2'b10,
        OP_SUB = 2'b11
    } elem_op_e;

    localparam int MASK_WORD_BITS = 64;
    localparam logic [2:0] GRP_RESERVED = 3'b100;
endpackage

// File: rtl/vseq_geom.sv
module vseq_geom #(
    parameter int VLENB_W = 6,
    parameter int IDX_W   = 12,
    parameter int ESZ_W   = 2
) (
    input  logic [2:0]         grp_code,
    input  logic [ESZ_W-1:0]   elem_lg,
    input  logic [2:0]         sew_lg,
    input  logic [VLENB_W-1:0] reg_bytes,
    output logic [IDX_W-1:0]   total,
    output logic               illegal
);
    import vseq_pkg::*;

    logic signed [4:0] emul_s;
    logic [3:0]        emul_u;
    logic [IDX_W-1:0]  span_bytes;

    always_comb begin
        emul_s     = $signed(5'(elem_lg)) - $signed(5'(sew_lg))
                   + $signed({{2{grp_code[2]}}, grp_code});
        emul_u     = emul_s[4] ? 4'd0 : emul_s[3:0];
        span_bytes = IDX_W'(reg_bytes) << emul_u;
        total      = span_bytes >> elem_lg;
        illegal    = (grp_code == GRP_RESERVED);
    end
endmodule

// File: rtl/vseq_mask_pick.sv
module vseq_mask_pick #(
    parameter int IDX_W = 12,
    localparam int MW_W = IDX_W - 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      mask_word,
    output logic [MW_W-1:0]  word_idx,
    output logic             bit_val
);
    always_comb begin
        word_idx = idx[IDX_W-1:6];
        bit_val  = mask_word[idx[5:0]];
    end
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    import vseq_pkg::*;

    always_comb begin
        unique case (elem_op_e'(op))
            OP_NOT:  y = ~a;
            OP_ADD:  y = a + b;
            OP_XOR:  y = a ^ b;
            default: y = a - b;
        endcase
    end
endmodule

// File: rtl/vec_mask_wr_seq.sv
module vec_mask_wr_seq #(
    parameter int MAX_VLENB  = 32,
    parameter int ELEM_BYTES = 8,
    localparam int VLENB_W   = $clog2(MAX_VLENB) + 1,
    localparam int IDX_W     = VLENB_W + 6,
    localparam int MW_W      = IDX_W - 6,
    localparam int ESZ_W     = $clog2($clog2(ELEM_BYTES) + 1),
    localparam int DATA_W    = ELEM_BYTES * 8,
    localparam int ADDR_W    = IDX_W + $clog2(ELEM_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IDX_W-1:0]      vstart_in,
    input  logic [IDX_W-1:0]      vl_in,
    input  logic                  no_mask,
    input  logic                  mask_fill,
    input  logic                  tail_fill,
    input  logic [2:0]            grp_code,
    input  logic [ESZ_W-1:0]      elem_lg,
    input  logic [2:0]            sew_lg,
    input  logic [VLENB_W-1:0]    reg_bytes,
    input  logic [1:0]            op_sel,
    output logic [MW_W-1:0]       mask_word_idx,
    input  logic [63:0]           mask_word,
    output logic [IDX_W-1:0]      src_idx,
    input  logic [DATA_W-1:0]     src_a,
    input  logic [DATA_W-1:0]     src_b,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [ELEM_BYTES-1:0] wr_be,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  busy,
    output logic                  done,
    output logic                  illegal,
    output logic [IDX_W-1:0]      vstart_out
);
    import vseq_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] vl;
        logic [IDX_W-1:0] total;
        logic             no_mask;
        logic             mfill;
        logic             tfill;
        logic             illegal;
        logic [ESZ_W-1:0] elg;
        logic [1:0]       op;
    } seq_t;

    localparam logic [ELEM_BYTES-1:0] BE_ONES = '1;

    seq_t q, d;

    logic [IDX_W-1:0]  geo_total;
    logic              geo_illegal;
    logic              mask_bit;
    logic [DATA_W-1:0] alu_y;
    logic [IDX_W-1:0]  idx_nxt;
    logic              elem_on;
    logic              tail_phase;

    vseq_geom #(.VLENB_W(VLENB_W), .IDX_W(IDX_W), .ESZ_W(ESZ_W)) geom_i (
        .grp_code (grp_code),
        .elem_lg  (elem_lg),
        .sew_lg   (sew_lg),
        .reg_bytes(reg_bytes),
        .total    (geo_total),
        .illegal  (geo_illegal)
    );

    vseq_mask_pick #(.IDX_W(IDX_W)) mpick_i (
        .idx      (q.idx),
        .mask_word(mask_word),
        .word_idx (mask_word_idx),
        .bit_val  (mask_bit)
    );

    vseq_alu #(.DATA_W(DATA_W)) alu_i (
        .op(q.op),
        .a (src_a),
        .b (src_b),
        .y (alu_y)
    );

    always_comb begin
        d          = q;
        idx_nxt    = q.idx + 1'b1;
        elem_on    = q.no_mask | mask_bit;
        src_idx    = q.idx;
        wr_en      = 1'b0;
        wr_data    = '0;
        wr_be      = ~(BE_ONES << (32'd1 << q.elg));
        wr_addr    = ADDR_W'(q.idx) << q.elg;
        busy       = (q.st != ST_IDLE);
        done       = (q.st == ST_FIN);
        illegal    = q.illegal;
        vstart_out = (q.st == ST_BODY) ? q.idx : '0;
        tail_phase = (q.st == ST_TAIL);

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.idx     = vstart_in;
                    d.vl      = vl_in;
                    d.total   = geo_total;
                    d.no_mask = no_mask;
                    d.mfill   = mask_fill;
                    d.tfill   = tail_fill;
                    d.illegal = geo_illegal;
                    d.elg     = elem_lg;
                    d.op      = op_sel;
                    d.st      = (geo_illegal || (vstart_in >= vl_in)) ? ST_FIN : ST_BODY;
                end
            end
            ST_BODY: begin
                wr_en   = elem_on | q.mfill;
                wr_data = elem_on ? alu_y : '1;
                d.idx   = idx_nxt;
                if (idx_nxt == q.vl) begin
                    d.st = (q.tfill && (q.vl < q.total)) ? ST_TAIL : ST_FIN;
                end
            end
            ST_TAIL: begin
                wr_en   = 1'b1;
                wr_data = '1;
                d.idx   = idx_nxt;
                if (idx_nxt == q.total) begin
                    d.st = ST_FIN;
                end
            end
            default: begin
                d.st  = ST_IDLE;
                d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
    parameter int ELEM_BYTES = 8,
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 15,
    parameter int IDX_W      = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  illegal,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [ELEM_BYTES-1:0] wr_be,
    input logic [DATA_W-1:0]     wr_data,
    input logic [IDX_W-1:0]      vstart_out,
    input logic                  tail_phase
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    p_vstart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || !busy) |-> (vstart_out == '0));

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);

    p_be_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be[0] && ((wr_be & (wr_be + 1'b1)) == '0)));

    p_addr_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr > $past(wr_addr)));

    p_tail_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tail_phase) |-> (&wr_data));
endmodule

bind vec_mask_wr_seq vseq_chk #(
    .ELEM_BYTES(ELEM_BYTES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .vstart_out(vstart_out),
    .tail_phase(tail_phase)
);

// File: tb/vec_mask_wr_seq_tb_top.sv
module vec_mask_wr_seq_tb_top;
    localparam int MAX_VLENB  = 32;
    localparam int ELEM_BYTES = 8;
    localparam int VLENB_W    = $clog2(MAX_VLENB) + 1;
    localparam int IDX_W      = VLENB_W + 6;
    localparam int MW_W       = IDX_W - 6;
    localparam int ESZ_W      = $clog2($clog2(ELEM_BYTES) + 1);
    localparam int DATA_W     = ELEM_BYTES * 8;
    localparam int ADDR_W     = IDX_W + $clog2(ELEM_BYTES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [IDX_W-1:0] vstart_in = '0, vl_in = '0;
    logic no_mask = 1'b1, mask_fill = 1'b0, tail_fill = 1'b0;
    logic [2:0] grp_code = '0, sew_lg = '0;
    logic [ESZ_W-1:0] elem_lg = '0;
    logic [VLENB_W-1:0] reg_bytes = '0;
    logic [1:0] op_sel = '0;
    logic [MW_W-1:0] mask_word_idx;
    logic [63:0] mask_word;
    logic [IDX_W-1:0] src_idx;
    logic [DATA_W-1:0] src_a, src_b;
    logic wr_en, busy, done, illegal;
    logic [ADDR_W-1:0] wr_addr;
    logic [ELEM_BYTES-1:0] wr_be;
    logic [DATA_W-1:0] wr_data;
    logic [IDX_W-1:0] vstart_out;

    logic [63:0] mask_mem [64];

    int errs = 0;
    int checks = 0;

    longint unsigned q_addr[$];
    longint unsigned q_be[$];
    longint unsigned q_data[$];

    always #2.5 clk = ~clk;

    vec_mask_wr_seq #(.MAX_VLENB(MAX_VLENB), .ELEM_BYTES(ELEM_BYTES)) dut_i (.*);

    function automatic logic [63:0] opnd_a(int i);
        return 64'h0123_4567_89AB_CDEF + 64'(i) * 64'h0000_1111_0101_0F0F;
    endfunction

    function automatic logic [63:0] opnd_b(int i);
        return 64'hF0F0_1234_5678_0FF1 ^ (64'(i) << 5);
    endfunction

    always_comb begin
        mask_word = mask_mem[mask_word_idx];
        src_a     = opnd_a(int'(src_idx));
        src_b     = opnd_b(int'(src_idx));
    end

    function automatic logic [63:0] be_bits(longint unsigned be);
        logic [63:0] m = '0;
        for (int k = 0; k < 8; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_mask(input logic [63:0] seed);
        for (int w = 0; w < 64; w++)
            mask_mem[w] = seed ^ (64'(w) * 64'h0123_4567_0F1E_2D3C);
    endtask

    // Runs one operation and compares every write against a model queue.
    task automatic run_op(input int vs, input int vl, input bit nm, input bit mf,
                          input bit tf, input int lm, input int el, input int sw,
                          input int rb, input int op, input int poke_at,
                          input string tag);
        int lmul_s, em, tot, esz, exp_cyc, cyc;
        bit ill, act;
        longint unsigned be, res;
        logic [63:0] a, b;
        ill    = (lm == 4);
        lmul_s = (lm >= 4) ? lm - 8 : lm;
        em     = el - sw + lmul_s;
        if (em < 0) em = 0;
        esz    = 1 << el;
        tot    = (rb << em) / esz;
        be     = (longint'(1) << esz) - 1;
        q_addr.delete(); q_be.delete(); q_data.delete();
        if (ill || vs >= vl) begin
            exp_cyc = 1;
        end else begin
            for (int i = vs; i < vl; i++) begin
                act = nm || mask_mem[i / 64][i % 64];
                a = opnd_a(i);
                b = opnd_b(i);
                case (op)
                    0: res = ~a;
                    1: res = a + b;
                    2: res = a ^ b;
                    default: res = a - b;
                endcase
                if (act) begin
                    q_addr.push_back(i * esz); q_be.push_back(be);
                    q_data.push_back(res & be_bits(be));
                end else if (mf) begin
                    q_addr.push_back(i * esz); q_be.push_back(be);
                    q_data.push_back(be_bits(be));
                end
            end
            exp_cyc = vl - vs + 1;
            if (tf && vl < tot) begin
                for (int i = vl; i < tot; i++) begin
                    q_addr.push_back(i * esz); q_be.push_back(be);
                    q_data.push_back(be_bits(be));
                end
                exp_cyc += tot - vl;
            end
        end

        @(negedge clk);
        vstart_in = IDX_W'(vs); vl_in = IDX_W'(vl);
        no_mask = nm; mask_fill = mf; tail_fill = tf;
        grp_code = 3'(lm); elem_lg = ESZ_W'(el); sew_lg = 3'(sw);
        reg_bytes = VLENB_W'(rb); op_sel = 2'(op);
        start = 1'b1;
        cyc = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == poke_at) begin
                start = 1'b1; grp_code = 3'b100; vl_in = 1; vstart_in = 0;
            end
            chk(busy === 1'b1, "R8", {tag, " busy during run"}, busy, 1);
            if (wr_en === 1'b1) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, tag, "unexpected write addr", wr_addr, 0);
                end else begin
                    longint unsigned ea, eb, ed;
                    ea = q_addr.pop_front(); eb = q_be.pop_front(); ed = q_data.pop_front();
                    chk(wr_addr == ea, tag, "write addr", wr_addr, ea);
                    chk(wr_be == eb, tag, "write byte enable", wr_be, eb);
                    chk((wr_data & be_bits(wr_be)) == ed, tag, "write data", wr_data, ed);
                end
            end
            if (done === 1'b1 || cyc > 5000) break;
        end
        chk(cyc == exp_cyc, "R2", {tag, " cycles to done, one element per clock"}, cyc, exp_cyc);
        chk(q_addr.size() == 0, tag, "missing writes", q_addr.size(), 0);
        chk(vstart_out == 0, "R8", {tag, " resume index cleared at done"}, vstart_out, 0);
        chk(illegal == ill, "R7", {tag, " illegal flag"}, illegal, ill);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R8", {tag, " idle after single done pulse"},
            {busy, done}, 0);
        chk(wr_en == 1'b0, "R8", {tag, " no write while idle"}, wr_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R8 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        fill_mask(64'hA5C3_96F0_0FF0_3C5A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && wr_en == 0 && illegal == 0 && vstart_out == 0,
            "R8", "reset state", {busy, done, wr_en, illegal}, 0);

        // R2 R9 R5: unmasked add, byte elements, tail filled to register end
        run_op(0, 10, 1, 0, 1, 0, 0, 0, 16, 1, 0, "R2 R5 R9 add");
        // R3 R4: masked with fill, resume at 3, group x2, 2-byte elements, no tail
        run_op(3, 14, 0, 1, 0, 1, 1, 1, 16, 3, 0, "R3 R4 R9 sub");
        // R4 R6: masked undisturbed, fractional group, tail past the maximum length
        run_op(0, 2, 0, 0, 1, 7, 2, 2, 16, 2, 0, "R4 R6 fractional");
        fill_mask(64'h0000_0000_0000_0000);
        run_op(0, 2, 0, 0, 1, 6, 3, 3, 32, 0, 0, "R4 R6 all masked");
        fill_mask(64'h3C5A_0FF0_96F0_A5C3);
        // R1: resume index equals length
        run_op(5, 5, 1, 1, 1, 0, 0, 0, 16, 1, 0, "R1 early exit");
        run_op(9, 4, 1, 1, 1, 0, 0, 0, 16, 1, 0, "R1 early exit beyond");
        // R7: reserved group code
        run_op(0, 8, 1, 1, 1, 4, 0, 0, 16, 1, 0, "R7 reserved");
        // R3 R10: word boundaries of the mask, start poked mid-run
        run_op(60, 200, 0, 1, 1, 3, 0, 0, 32, 2, 5, "R3 R10 multiword");
        // R6 R9: wider element than selected width, not, no tail
        run_op(0, 16, 1, 0, 1, 0, 1, 0, 16, 0, 0, "R6 R9 not widened");
        // R5: tail fill off, 8-byte elements
        run_op(1, 3, 0, 1, 0, 2, 3, 3, 16, 1, 0, "R5 no tail");
        // R7: legal start after illegal clears flag
        run_op(0, 4, 1, 0, 0, 0, 2, 2, 16, 3, 0, "R7 recovery");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule